// File: doc/BRIEF.md
# Synchronous Glitch-Free Clock Stop Controller

This block decides, cycle by cycle, which of a clock generator's output clocks are allowed to toggle. It gates a bank of processor-domain clocks and a bank of bus-domain clocks, and it also gates a free-running bus reference clock. Two active-low stop requests control the processor and bus banks. An active-low power-down input controls all outputs, including the free-running bus reference clock. The free-running reference clock paces the whole block. A request is first brought into the reference domain and then captured on one reference rising edge. After that it is applied at the next falling edge of the clock it controls. Because of this, a gated output never makes a shortened high pulse.

Power-down takes effect at once. It clears every enable asynchronously and drops the enable for the remaining fixed-frequency clocks. When power returns, a parameterised count of reference cycles stands in for the oscillator settling time. Every output stays low until that count has elapsed. Stop requests that change while the block is powered down are honoured as soon as power-up completes.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `cpu_stop_n` is 0 every bit of `cpu_clk_o` stays low. While it is 1 (and the block is powered and settled) all bits of `cpu_clk_o` toggle together with `cpu_src_clk`.
- R2: While `pci_stop_n` is 0 every bit of `pci_clk_o` stays low, and `pcif_clk_o` keeps toggling with `ref_clk`.
- R3: A stopped output is held at logic 0, never at logic 1.
- R4: A change on a stop request passes through a two-flop synchroniser and is captured on the third `ref_clk` rising edge after it. It is then applied at the next falling edge of the gated source clock. No change reaches the output before that third edge.
- R5: While power is up, every high pulse on a gated output lasts a full high phase of its source clock. An enable changes only while its source clock is low.
- R6: `pwrdn_n` = 0 forces all outputs and `other_en_o` to 0 at once, whatever the stop requests are.
- R7: After `pwrdn_n` or `rst_n` returns to 1, all outputs and `other_en_o` stay 0 for at least `STABLE_CYCLES` rising edges of `ref_clk`. After that, `other_en_o` = 1 and `pcif_clk_o` runs.
- R8: A stop request that is set while the block is powered down takes effect at power-up. The stopped bank never toggles, and the other banks start normally.
- R9: While `rst_n` = 0, all outputs and `other_en_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running bus reference clock; paces the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src_clk | input | 1 | Source for the processor-domain outputs |
| pci_src_clk | input | 1 | Source for the bus-domain outputs |
| cpu_stop_n | input | 1 | Active-low stop request, processor bank |
| pci_stop_n | input | 1 | Active-low stop request, bus bank |
| pwrdn_n | input | 1 | Active-low power-down |
| cpu_clk_o | output | NCPU | Gated processor-domain clocks |
| pci_clk_o | output | NPCI | Gated bus-domain clocks |
| pcif_clk_o | output | 1 | Gated reference clock; stops only on power-down |
| other_en_o | output | 1 | Enable for the remaining fixed-frequency clocks |

## Verification
The assertions check three things on every cycle. First, an enable never changes while its source clock is high. Second, power-down holds every output low. Third, the outputs stay disabled until the settle window has passed, and a request held low for three reference edges has cleared its captured run flag. The bench scenarios are needed to show the rest: the measured widths of the high pulses, the exact reference edge where a stop or start first shows at the pins, that the bus stop leaves the reference output untouched, and that a request set during power-down still holds after power-up.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WAIT = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/clkstop_pwrseq.sv
module clkstop_pwrseq
  import clkstop_pkg::*;
#(
  parameter int STABLE_CYCLES = 100000
) (
  input  logic clk,
  input  logic clr_n,
  output logic ready_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

  pwr_state_e    st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      st_q  <= PWR_OFF;
      cnt_q <= '0;
    end else begin
      case (st_q)
        PWR_OFF: begin
          st_q  <= PWR_WAIT;
          cnt_q <= '0;
        end
        PWR_WAIT: begin
          if (cnt_q == LAST) st_q <= PWR_ON;
          else               cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign ready_o = (st_q == PWR_ON);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int N = 1
) (
  input  logic         ref_clk,
  input  logic         clr_n,
  input  logic         src_clk,
  input  logic         run_i,
  output logic         req_o,
  output logic         en_o,
  output logic [N-1:0] clk_o
);
  logic req_q;
  logic en_q;

  // request captured on a reference rising edge
  always_ff @(posedge ref_clk or negedge clr_n) begin
    if (!clr_n) req_q <= 1'b0;
    else        req_q <= run_i;
  end

  // enable only moves while the source is low
  always_ff @(negedge src_clk or negedge clr_n) begin
    if (!clr_n) en_q <= 1'b0;
    else        en_q <= req_q;
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign clk_o[g] = src_clk & en_q;
  end

  assign req_o = req_q;
  assign en_o  = en_q;
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int NCPU          = 4,
  parameter int NPCI          = 7,
  parameter int STABLE_CYCLES = 100000
) (
  input  logic            ref_clk,
  input  logic            rst_n,
  input  logic            cpu_src_clk,
  input  logic            pci_src_clk,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            pwrdn_n,
  output logic [NCPU-1:0] cpu_clk_o,
  output logic [NPCI-1:0] pci_clk_o,
  output logic            pcif_clk_o,
  output logic            other_en_o
);
  logic       clr_n;
  logic       clr_sync_n;
  logic [1:0] stop_n_s;
  logic       ready;
  logic       cpu_req, pci_req, pcif_req;
  logic       cpu_en, pci_en, pcif_en;
  logic [0:0] pcif_vec;

  assign clr_n = rst_n & pwrdn_n;

  // release of the clear is synchronised; assertion is immediate
  clkstop_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clr_sync (
    .clk(ref_clk), .rst_n(clr_n), .d_i(1'b1), .q_o(clr_sync_n)
  );

  clkstop_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_req_sync (
    .clk(ref_clk), .rst_n(rst_n), .d_i({pci_stop_n, cpu_stop_n}), .q_o(stop_n_s)
  );

  clkstop_pwrseq #(.STABLE_CYCLES(STABLE_CYCLES)) u_pwr (
    .clk(ref_clk), .clr_n(clr_sync_n), .ready_o(ready)
  );

  clkstop_gate #(.N(NCPU)) u_cpu_gate (
    .ref_clk(ref_clk), .clr_n(clr_n), .src_clk(cpu_src_clk),
    .run_i(ready & stop_n_s[0]), .req_o(cpu_req), .en_o(cpu_en), .clk_o(cpu_clk_o)
  );

  clkstop_gate #(.N(NPCI)) u_pci_gate (
    .ref_clk(ref_clk), .clr_n(clr_n), .src_clk(pci_src_clk),
    .run_i(ready & stop_n_s[1]), .req_o(pci_req), .en_o(pci_en), .clk_o(pci_clk_o)
  );

  clkstop_gate #(.N(1)) u_pcif_gate (
    .ref_clk(ref_clk), .clr_n(clr_n), .src_clk(ref_clk),
    .run_i(ready), .req_o(pcif_req), .en_o(pcif_en), .clk_o(pcif_vec)
  );

  assign pcif_clk_o = pcif_vec[0];
  assign other_en_o = ready;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int NCPU          = 4,
  parameter int NPCI          = 7,
  parameter int STABLE_CYCLES = 100000
) (
  input logic            ref_clk,
  input logic            rst_n,
  input logic            cpu_src_clk,
  input logic            pci_src_clk,
  input logic            cpu_stop_n,
  input logic            pci_stop_n,
  input logic            pwrdn_n,
  input logic [NCPU-1:0] cpu_clk_o,
  input logic [NPCI-1:0] pci_clk_o,
  input logic            pcif_clk_o,
  input logic            other_en_o,
  input logic            cpu_req,
  input logic            pci_req,
  input logic            cpu_en,
  input logic            pci_en,
  input logic            pcif_en
);
  int unsigned up_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                            up_cnt <= 0;
    else if (!pwrdn_n)                     up_cnt <= 0;
    else if (up_cnt < STABLE_CYCLES + 8)   up_cnt <= up_cnt + 1;
  end

  assert_pd_forces_low_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pwrdn_n |-> (!other_en_o && cpu_clk_o == '0 && pci_clk_o == '0 && !pcif_clk_o));

  assert_settle_window_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    other_en_o |-> (up_cnt >= STABLE_CYCLES));

  assert_req_needs_power_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (cpu_req || pci_req) |-> other_en_o);

  assert_cpu_stop_latency_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cpu_stop_n && !$past(cpu_stop_n) && !$past(cpu_stop_n, 2)) |=> !cpu_req);

  assert_pci_stop_latency_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!pci_stop_n && !$past(pci_stop_n) && !$past(pci_stop_n, 2)) |=> !pci_req);

  always @(negedge ref_clk) begin
    if (!rst_n) begin
      assert_reset_low_R9: assert (!other_en_o && cpu_clk_o == '0 && pci_clk_o == '0 && !pcif_clk_o);
    end
  end

  // R5: enables move only while their source is low
  always @(cpu_en) begin
    if (rst_n && pwrdn_n) begin
      assert_cpu_glitch_free_R5: assert (!cpu_src_clk);
    end
  end

  always @(pci_en) begin
    if (rst_n && pwrdn_n) begin
      assert_pci_glitch_free_R5: assert (!pci_src_clk);
    end
  end

  always @(pcif_en) begin
    if (rst_n && pwrdn_n) begin
      assert_pcif_glitch_free_R5: assert (!ref_clk);
    end
  end
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .NCPU(NCPU), .NPCI(NPCI), .STABLE_CYCLES(STABLE_CYCLES)
) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .cpu_src_clk(cpu_src_clk), .pci_src_clk(pci_src_clk),
  .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
  .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o),
  .other_en_o(other_en_o), .cpu_req(cpu_req), .pci_req(pci_req),
  .cpu_en(cpu_en), .pci_en(pci_en), .pcif_en(pcif_en)
);

// File: tb/clkstop_ctrl_test.sv
`timescale 1ns/1ps
module clkstop_ctrl_test;
  localparam int NCPU   = 4;
  localparam int NPCI   = 7;
  localparam int STABLE = 20;
  localparam int SETTLE = 8;
  localparam int OBS    = 12;

  logic ref_clk = 1'b0, cpu_src_clk = 1'b0, pci_src_clk = 1'b0;
  logic rst_n, pwrdn_n, cpu_stop_n, pci_stop_n;
  logic [NCPU-1:0] cpu_clk_o;
  logic [NPCI-1:0] pci_clk_o;
  logic pcif_clk_o, other_en_o;

  always #4 ref_clk     = ~ref_clk;
  always #3 cpu_src_clk = ~cpu_src_clk;
  always #5 pci_src_clk = ~pci_src_clk;

  clkstop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .STABLE_CYCLES(STABLE)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .cpu_src_clk(cpu_src_clk), .pci_src_clk(pci_src_clk),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o), .pcif_clk_o(pcif_clk_o),
    .other_en_o(other_en_o)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // rising-edge totals and pulse-width monitors
  int cpu_tot = 0, pci_tot = 0, pcif_tot = 0;
  int runt_cpu = 0, runt_pci = 0, runt_pcif = 0;
  realtime t_cpu, t_pci, t_pcif;
  bit ok_cpu, ok_pci, ok_pcif;

  always @(posedge cpu_clk_o[0]) begin cpu_tot++; t_cpu = $realtime; ok_cpu = rst_n && pwrdn_n; end
  always @(posedge pci_clk_o[0]) begin pci_tot++; t_pci = $realtime; ok_pci = rst_n && pwrdn_n; end
  always @(posedge pcif_clk_o)   begin pcif_tot++; t_pcif = $realtime; ok_pcif = rst_n && pwrdn_n; end

  always @(negedge cpu_clk_o[0])
    if (ok_cpu && rst_n && pwrdn_n && ($realtime - t_cpu) < 2.99) runt_cpu++;
  always @(negedge pci_clk_o[0])
    if (ok_pci && rst_n && pwrdn_n && ($realtime - t_pci) < 4.99) runt_pci++;
  always @(negedge pcif_clk_o)
    if (ok_pcif && rst_n && pwrdn_n && ($realtime - t_pcif) < 3.99) runt_pcif++;

  // scoreboard
  typedef struct {
    bit    cpu_run;
    bit    pci_run;
    bit    pcif_run;
    bit    oth;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic expect_state(bit c, bit p, bit f, bit o, string tag);
    exp_t it;
    repeat (SETTLE) @(negedge ref_clk);
    it.cpu_run = c; it.pci_run = p; it.pcif_run = f; it.oth = o; it.tag = tag;
    exp_q.push_back(it);
    while (exp_q.size() != 0) @(negedge ref_clk);
  endtask

  initial begin : monitor
    forever begin
      exp_t it;
      int s_c, s_p, s_f, hi_c, hi_p, hi_f, mism;
      while (exp_q.size() == 0) @(negedge ref_clk);
      it = exp_q[0];
      s_c = cpu_tot; s_p = pci_tot; s_f = pcif_tot;
      hi_c = 0; hi_p = 0; hi_f = 0; mism = 0;
      for (int k = 0; k < OBS; k++) begin
        @(negedge ref_clk); #0.5;
        if (cpu_clk_o != '0 && cpu_clk_o != '1) mism++;
        if (pci_clk_o != '0 && pci_clk_o != '1) mism++;
        if (!it.cpu_run  && cpu_clk_o != '0) hi_c++;
        if (!it.pci_run  && pci_clk_o != '0) hi_p++;
        if (!it.pcif_run && pcif_clk_o)      hi_f++;
      end
      if (it.cpu_run) chk(cpu_tot - s_c >= 2, it.tag, "cpu running edges", cpu_tot - s_c, 2);
      else            chk(cpu_tot == s_c && hi_c == 0, it.tag, "cpu stopped low (R3)", cpu_tot - s_c + hi_c, 0);
      if (it.pci_run) chk(pci_tot - s_p >= 2, it.tag, "pci running edges", pci_tot - s_p, 2);
      else            chk(pci_tot == s_p && hi_p == 0, it.tag, "pci stopped low (R3)", pci_tot - s_p + hi_p, 0);
      if (it.pcif_run) chk(pcif_tot - s_f >= 2, it.tag, "pcif running edges", pcif_tot - s_f, 2);
      else             chk(pcif_tot == s_f && hi_f == 0, it.tag, "pcif stopped low", pcif_tot - s_f + hi_f, 0);
      chk(other_en_o == it.oth, it.tag, "other_en_o", int'(other_en_o), int'(it.oth));
      chk(mism == 0, it.tag, "bank bits move together", mism, 0);
      void'(exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    int s;
    rst_n = 1'b1; pwrdn_n = 1'b1; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    #1 rst_n = 1'b0;
    expect_state(0, 0, 0, 0, "R9");

    // R7: settle window after reset release
    @(negedge ref_clk); #1 rst_n = 1'b1;
    s = cpu_tot + pci_tot + pcif_tot;
    repeat (STABLE) @(posedge ref_clk);
    #1 chk((cpu_tot + pci_tot + pcif_tot) == s && !other_en_o, "R7", "quiet during settle",
           cpu_tot + pci_tot + pcif_tot - s + int'(other_en_o), 0);
    repeat (10) @(posedge ref_clk);
    expect_state(1, 1, 1, 1, "R7");

    cpu_stop_n = 1'b0;
    expect_state(0, 1, 1, 1, "R1");
    cpu_stop_n = 1'b1; pci_stop_n = 1'b0;
    expect_state(1, 0, 1, 1, "R2");
    cpu_stop_n = 1'b0;
    expect_state(0, 0, 1, 1, "R3");
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
    expect_state(1, 1, 1, 1, "R1");

    // R4: stop latency on the processor bank
    @(negedge ref_clk); #1 cpu_stop_n = 1'b0;
    @(posedge ref_clk); @(posedge ref_clk); #1 s = cpu_tot;
    @(posedge ref_clk); #0.5;
    chk(cpu_tot - s >= 1, "R4", "still running up to third edge", cpu_tot - s, 1);
    #7 s = cpu_tot;
    #40 chk(cpu_tot == s && cpu_clk_o == '0, "R4", "stopped after third edge", cpu_tot - s, 0);

    // R4: start latency
    @(negedge ref_clk); #1 cpu_stop_n = 1'b1; s = cpu_tot;
    @(posedge ref_clk); @(posedge ref_clk); @(posedge ref_clk); #0.5;
    chk(cpu_tot == s, "R4", "no restart before third edge", cpu_tot - s, 0);
    s = cpu_tot;
    #13 chk(cpu_tot > s, "R4", "restart after third edge", cpu_tot - s, 1);

    // R6: power-down is immediate, even with the reference high
    @(posedge ref_clk); #1 pwrdn_n = 1'b0;
    #0.1 chk(!pcif_clk_o && !other_en_o && cpu_clk_o == '0 && pci_clk_o == '0, "R6",
             "outputs low at once", int'(pcif_clk_o) + int'(other_en_o), 0);
    pci_stop_n = 1'b0;
    expect_state(0, 0, 0, 0, "R6");

    // R8: request set during power-down holds after power-up
    cpu_stop_n = 1'b0; pci_stop_n = 1'b1;
    @(negedge ref_clk); #1 pwrdn_n = 1'b1;
    s = cpu_tot;
    repeat (STABLE + 12) @(posedge ref_clk);
    chk(cpu_tot == s, "R8", "cpu never toggled through power-up", cpu_tot - s, 0);
    expect_state(0, 1, 1, 1, "R8");
    cpu_stop_n = 1'b1;
    expect_state(1, 1, 1, 1, "R1");

    chk(runt_cpu == 0,  "R5", "cpu short pulses",  runt_cpu, 0);
    chk(runt_pci == 0,  "R5", "pci short pulses",  runt_pci, 0);
    chk(runt_pcif == 0, "R5", "pcif short pulses", runt_pcif, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule